// File: doc/BRIEF.md
# Three-Lane Character Skew Aligner

This block sits behind three serial-to-parallel capture lanes of a digital video receiver. Each lane delivers recovered 10-bit characters with its own valid strobe. Each lane may be sampled on a different phase of the oversampling clock, so characters that the transmitter sent in the same slot can reach this block in different cycles. Every lane also flags whether its character is a control (blanking) character or active data.

The block holds each lane in a small FIFO and searches every lane for an alignment marker. The marker is the first control character that follows active data. A lane that finds its marker stops and waits for the others. If all three markers turn up close enough together, the block locks. From then on it reads the three FIFOs in lock-step, so the three characters of one transmit slot leave the block in the same cycle. A FIFO fault while locked drops the lock and starts the search again.

Top module: `chanAlign`

## Requirements
- R1: A synchronous reset empties all three FIFOs and returns the search to its start. In the first cycle after reset is released, with no input, `outValid` and `aligned` are both low.
- R2: Each lane has its own FIFO, 4 entries deep by default. A lane's FIFO is written only when that lane's `inValid` bit is high, independently of the other lanes. A write is accepted when the FIFO is not full, or when it is read in the same cycle.
- R3: On a lane, the marker is the first character with its `inBlank` bit set to 1 that follows a character with `inBlank` at 0. Control characters that come before any active character are not markers. While searching, the lane discards every character ahead of its marker.
- R4: A lane whose FIFO head is its marker stops reading. When all three lanes hold their markers and the last one was found no more than 2 cycles after the first, the three markers are read together. On that same clock edge `aligned` rises and `outValid` first presents the three markers.
- R5: If the markers are spread over more than 2 cycles, or a stalled lane overflows while searching, the block does not lock. It flushes all FIFOs and searches again, and `aligned` stays low.
- R6: While aligned, the three FIFOs are read together in every cycle in which all three hold data. The three words appear on `outData` one clock edge after the read, with `outValid` high. Lane i occupies bits [10i+9:10i]. Characters from the same transmit slot leave in the same cycle, in the order they were sent.
- R7: While aligned, either of two faults drops `aligned` on the next clock edge and flushes all FIFOs: a write to a full FIFO that is not read in that cycle, or any FIFO being full while another is empty.
- R8: `outValid` is high only in cycles in which `aligned` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock shared by all lanes |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 30 | Three 10-bit input characters, lane i in bits [10i+9:10i] |
| inValid | input | 3 | Per-lane write strobe |
| inBlank | input | 3 | Per-lane flag: 1 marks a control (blanking) character |
| outData | output | 30 | Three aligned 10-bit characters, lane i in bits [10i+9:10i] |
| outValid | output | 1 | The three words on outData are a valid aligned triple |
| aligned | output | 1 | The lanes are locked to a common slot |

## Verification
The bench builds the block with its default parameters: a FIFO depth of 4 and a lock window of 2 cycles. With these values, a lane skew of exactly 2 cycles drives the leading FIFO completely full just before the lock, which puts the boundary between lock and overflow within reach. A skew of 3 crosses into the rejected case. Stopping the valid strobe of one lane while the other two keep running exercises the skew fault that breaks the lock.

// File: rtl/chanAlignPkg.sv
package chanAlignPkg;

  localparam int unsigned LANES = 3;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic [LANES-1:0] pop;    // read one entry from each flagged lane FIFO
    logic             flush;  // empty every lane FIFO
    logic             emit;   // register the head triple as an output word
  } ctlStrobe_t;

endpackage

// File: rtl/laneFifo.sv
module laneFifo #(
  parameter int unsigned WIDTH = 11,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty,
  output logic             full,
  output logic             overflow
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [CW-1:0]    count;
  logic             doWr;
  logic             doRd;

  function automatic logic [AW-1:0] bumpPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign doRd     = rdEn && !empty;
  assign doWr     = wrEn && (!full || doRd);
  assign overflow = wrEn && full && !doRd;
  assign rdData   = store[rdPtr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= bumpPtr(wrPtr);
      if (doRd) rdPtr <= bumpPtr(rdPtr);
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doWr && !rst && !flush) store[wrPtr] <= wrData;
  end

  // R2: occupancy never exceeds the configured depth
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R2: an accepted write with no read raises occupancy by one
  a_r2_write_counts: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !full && !rdEn && !flush) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/chanAlignPath.sv
module chanAlignPath
  import chanAlignPkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [LANES-1:0]        inValid,
  input  logic [LANES-1:0]        inBlank,
  input  ctlStrobe_t              ctl,
  output logic [LANES-1:0]        laneEmpty,
  output logic [LANES-1:0]        laneFull,
  output logic [LANES-1:0]        laneOverflow,
  output logic [LANES-1:0]        headBlank,
  output logic [LANES*DATA_W-1:0] outData,
  output logic                    outValid
);

  localparam int unsigned ENTRY_W = DATA_W + 1;

  logic [DATA_W-1:0] headWord [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ENTRY_W-1:0] rdEntry;

    laneFifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .flush    (ctl.flush),
      .wrEn     (inValid[i]),
      .wrData   ({inBlank[i], inData[i*DATA_W +: DATA_W]}),
      .rdEn     (ctl.pop[i]),
      .rdData   (rdEntry),
      .empty    (laneEmpty[i]),
      .full     (laneFull[i]),
      .overflow (laneOverflow[i])
    );

    assign headBlank[i] = rdEntry[DATA_W];
    assign headWord[i]  = rdEntry[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctl.emit;
      if (ctl.emit) begin
        for (int i = 0; i < LANES; i++) outData[i*DATA_W +: DATA_W] <= headWord[i];
      end
    end
  end

  // R6: an emitted triple is read from every lane in the same cycle
  a_r6_emit_reads_all: assert property (@(posedge clk) disable iff (rst)
    ctl.emit |-> (&ctl.pop && !(|laneEmpty)));

endmodule

// File: rtl/chanAlignCtrl.sv
module chanAlignCtrl
  import chanAlignPkg::*;
#(
  parameter int unsigned WINDOW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] laneEmpty,
  input  logic [LANES-1:0] laneFull,
  input  logic [LANES-1:0] laneOverflow,
  input  logic [LANES-1:0] headBlank,
  output ctlStrobe_t       ctl,
  output logic             aligned
);

  localparam int unsigned WCW = $clog2(WINDOW + 2);
  localparam logic [WCW-1:0] WAIT_MAX = WCW'(WINDOW + 1);

  typedef enum logic {HUNT, LOCKED} alignState_t;

  alignState_t      state;
  logic [LANES-1:0] foundQ;
  logic [LANES-1:0] prevActQ;
  logic [WCW-1:0]   waitCnt;

  logic [LANES-1:0] markerAt;
  logic [LANES-1:0] huntPop;
  logic             allFound;
  logic             anyFound;
  logic             lockNow;
  logic             spreadBad;
  logic             skewFault;
  logic             fault;
  logic             readAll;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      markerAt[i] = !laneEmpty[i] && headBlank[i] && prevActQ[i];
      huntPop[i]  = !foundQ[i] && !laneEmpty[i] && !markerAt[i];
    end
    allFound  = &foundQ;
    anyFound  = |foundQ;
    lockNow   = (state == HUNT) && allFound && (waitCnt <= WCW'(WINDOW));
    spreadBad = (state == HUNT) && allFound && (waitCnt > WCW'(WINDOW));
    skewFault = (state == LOCKED) && (|laneFull) && (|laneEmpty);
    fault     = (|laneOverflow) || skewFault || spreadBad;
    readAll   = ((state == LOCKED) || lockNow) && !(|laneEmpty);

    ctl.pop   = (state == LOCKED || lockNow) ? {LANES{readAll}} : huntPop;
    ctl.flush = fault;
    ctl.emit  = readAll && !fault;
  end

  always_ff @(posedge clk) begin
    if (rst || fault) begin
      state    <= HUNT;
      foundQ   <= '0;
      prevActQ <= '0;
      waitCnt  <= '0;
    end else if (state == HUNT) begin
      foundQ <= foundQ | markerAt;
      for (int i = 0; i < LANES; i++) begin
        if (huntPop[i]) prevActQ[i] <= !headBlank[i];
      end
      if (!anyFound)                             waitCnt <= '0;
      else if (!allFound && waitCnt != WAIT_MAX) waitCnt <= waitCnt + 1'b1;
      if (lockNow) state <= LOCKED;
    end
  end

  assign aligned = (state == LOCKED);

  // R4: lock is only entered with every lane holding its marker inside the window
  a_r4_lock_needs_markers: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> $past(allFound && waitCnt <= WCW'(WINDOW)));

  // R5: a spread wider than the window returns to an empty search
  a_r5_spread_rejected: assert property (@(posedge clk) disable iff (rst)
    spreadBad |=> (!aligned && foundQ == '0));

  // R7: a lane fault while locked drops the lock on the next edge
  a_r7_fault_unlocks: assert property (@(posedge clk) disable iff (rst)
    (aligned && ((|laneOverflow) || ((|laneFull) && (|laneEmpty)))) |=> !aligned);

  // R4: a lane that already holds its marker is never read while searching
  a_r4_marker_stalls: assert property (@(posedge clk) disable iff (rst)
    (state == HUNT && !lockNow) |-> ((ctl.pop & foundQ) == '0));

endmodule

// File: rtl/chanAlign.sv
module chanAlign
  import chanAlignPkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned WINDOW = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [LANES-1:0]        inValid,
  input  logic [LANES-1:0]        inBlank,
  output logic [LANES*DATA_W-1:0] outData,
  output logic                    outValid,
  output logic                    aligned
);

  ctlStrobe_t       ctl;
  logic [LANES-1:0] laneEmpty;
  logic [LANES-1:0] laneFull;
  logic [LANES-1:0] laneOverflow;
  logic [LANES-1:0] headBlank;

  chanAlignPath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_path (
    .clk          (clk),
    .rst          (rst),
    .inData       (inData),
    .inValid      (inValid),
    .inBlank      (inBlank),
    .ctl          (ctl),
    .laneEmpty    (laneEmpty),
    .laneFull     (laneFull),
    .laneOverflow (laneOverflow),
    .headBlank    (headBlank),
    .outData      (outData),
    .outValid     (outValid)
  );

  chanAlignCtrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .laneEmpty    (laneEmpty),
    .laneFull     (laneFull),
    .laneOverflow (laneOverflow),
    .headBlank    (headBlank),
    .ctl          (ctl),
    .aligned      (aligned)
  );

  // R8: output words only appear while locked
  a_r8_valid_only_aligned: assert property (@(posedge clk) disable iff (rst)
    outValid |-> aligned);

  // R1: the cycle after reset shows an idle, unlocked block
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && !aligned));

endmodule

// File: tb/tb_chanAlign.sv
module tb_chanAlign;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 3;
  localparam int DW = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NL*DW-1:0] inData = '0;
  logic [NL-1:0]  inValid = '0;
  logic [NL-1:0]  inBlank = '0;
  logic [NL*DW-1:0] outData;
  logic           outValid;
  logic           aligned;

  chanAlign dut (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inBlank(inBlank),
    .outData(outData), .outValid(outValid), .aligned(aligned)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  // transmit-slot delay line, index = skew in cycles
  bit       hv [4];
  bit       hb [4];
  bit [7:0] hs [4];
  int       sk [NL];

  int  slot;
  bit  curBlank;
  int  runLeft;
  bit  seenActive;
  int  markerSlot;

  bit  sawLock, sawDrop, gotFirst, firstDone;
  int  lastSlot, outCount;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wordOf(input int lane, input bit [7:0] s);
    return {lane[1:0], s};
  endfunction

  task automatic startStream();
    slot       = int'($urandom % 256);
    curBlank   = 1'b1;
    runLeft    = 4 + int'($urandom % 6);
    seenActive = 1'b0;
    markerSlot = -1;
    for (int k = 0; k < 4; k++) begin hv[k] = 0; hb[k] = 0; hs[k] = 0; end
  endtask

  task automatic stepGen(input bit gapOk, input bit stall0);
    bit issue;
    issue = !gapOk || (($urandom % 8) != 0);
    for (int k = 3; k > 0; k--) begin hv[k] = hv[k-1]; hb[k] = hb[k-1]; hs[k] = hs[k-1]; end
    hv[0] = issue;
    hb[0] = curBlank;
    hs[0] = 8'(slot);
    if (issue) begin
      if (markerSlot < 0 && curBlank && seenActive) markerSlot = slot % 256;
      if (!curBlank) seenActive = 1'b1;
      slot = (slot + 1) % 256;
      runLeft--;
      if (runLeft == 0) begin
        curBlank = !curBlank;
        runLeft  = 4 + int'($urandom % 6);
      end
    end
    for (int c = 0; c < NL; c++) begin
      inValid[c] = hv[sk[c]] && !(stall0 && c == 0);
      inBlank[c] = hb[sk[c]];
      inData[c*DW +: DW] = wordOf(c, hs[sk[c]]);
    end
  endtask

  task automatic observe();
    int s0;
    if (aligned) sawLock = 1'b1;
    if (sawLock && !aligned) begin sawDrop = 1'b1; gotFirst = 1'b0; end
    if (outValid) begin
      outCount++;
      s0 = int'(outData[7:0]);
      check(aligned, "R8 outValid while aligned", int'(aligned), 1);
      for (int c = 0; c < NL; c++) begin
        check(int'(outData[c*DW+8 +: 2]) == c, "R6 lane placement", int'(outData[c*DW+8 +: 2]), c);
        check(int'(outData[c*DW +: 8]) == s0, "R6 same slot across lanes", int'(outData[c*DW +: 8]), s0);
      end
      if (!gotFirst) begin
        if (!firstDone) begin
          check(s0 == markerSlot, "R3 R4 first triple is the marker", s0, markerSlot);
          firstDone = 1'b1;
        end
        gotFirst = 1'b1;
      end else begin
        check(s0 == (lastSlot + 1) % 256, "R6 slot order", s0, (lastSlot + 1) % 256);
      end
      lastSlot = s0;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = '0; inBlank = '0; inData = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid, "R1 outValid after reset", int'(outValid), 0);
    check(!aligned, "R1 aligned after reset", int'(aligned), 0);
  endtask

  task automatic runEpisode(input int s0, input int s1, input int s2, input int cycles,
                            input bit gapOk, input int stallAt);
    int lo, hi;
    bit expectLock;
    sk[0] = s0; sk[1] = s1; sk[2] = s2;
    lo = s0; hi = s0;
    for (int c = 1; c < NL; c++) begin
      if (sk[c] < lo) lo = sk[c];
      if (sk[c] > hi) hi = sk[c];
    end
    expectLock = (hi - lo) <= 2;
    doReset();
    startStream();
    sawLock = 0; sawDrop = 0; gotFirst = 0; firstDone = 0; lastSlot = 0; outCount = 0;
    for (int cyc = 0; cyc < cycles; cyc++) begin
      @(negedge clk);
      observe();
      if (stallAt >= 0 && cyc == stallAt) begin
        check(aligned, "R7 locked before lane stall", int'(aligned), 1);
      end
      if (stallAt >= 0 && cyc == stallAt + 8) begin
        check(!aligned, "R7 lane stall drops aligned", int'(aligned), 0);
        check(!outValid, "R8 no output after fault", int'(outValid), 0);
      end
      stepGen(gapOk, stallAt >= 0 && cyc >= stallAt && cyc < stallAt + 8);
    end
    if (expectLock) begin
      check(sawLock, "R4 lock within window", int'(sawLock), 1);
      check(outCount > 0, "R6 triples emitted", outCount, 1);
      if (stallAt < 0) check(!sawDrop, "R4 lock held", int'(sawDrop), 0);
    end else begin
      check(!sawLock, "R5 spread beyond window rejected", int'(sawLock), 0);
      check(outCount == 0, "R5 no output without lock", outCount, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1, R2, R3, R4: equal skew, no gaps
    runEpisode(0, 0, 0, 200, 1'b0, -1);
    // R4 boundary: spread of exactly 2 with gaps
    runEpisode(2, 0, 1, 200, 1'b1, -1);
    runEpisode(1, 1, 1, 200, 1'b1, -1);
    runEpisode(0, 2, 2, 200, 1'b0, -1);
    // R5: spread of 3 never locks
    runEpisode(3, 0, 0, 200, 1'b0, -1);
    runEpisode(0, 3, 1, 200, 1'b1, -1);
    // R7: stop lane 0 while locked
    runEpisode(0, 1, 2, 240, 1'b0, 150);
    // random skews and gaps, R2 lanes driven independently
    for (int n = 0; n < 8; n++) begin
      runEpisode(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), 200, 1'b1, -1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule